// File: doc/BRIEF.md
# Dual-Port Disk Task-File Register Bank

This block stands in for the small register file that a disk-drive host interface presents. A host reaches it through a chip select, a 4-bit register address, separate read and write strobes and a 16-bit data path. A local controller reaches the same storage through a synchronous memory-mapped port. Because the bank answers every host strobe in hardware, the controller never has to respond to a host access in real time. It can inspect and update registers whenever its firmware gets to them. A one-cycle flag per register tells it which register the host has just changed.

The host strobes are asynchronous to the system clock. They pass through a two-flop synchronizer, and the bank acts on their edges. The address, chip select and data are sampled while the strobe is seen high. A write is committed after the strobe's trailing edge. Read data is latched when the leading edge is recognised. The shared host bus is split at the block edge into an input, an output and an output enable, so the pad ring can build the tristate driver. The enable is only ever asserted during a selected read.

The system clock must run at 50 MHz or faster so that a 100 ns strobe is always seen. With the default two synchronizer stages, a strobe must stay active for at least three clock cycles. Address, chip select and write data must stay valid for at least one clock cycle after the write strobe ends.

Top module: `taskfile_bank`

## Requirements
- R1: While and after reset, all sixteen registers read as zero, `host_doe` is low, `fw_rdata` is zero and `host_wr_flag` is zero.
- R2: A host write with `host_cs` high stores `host_din` into the register at `host_addr` within eight clock cycles after `host_wr` falls. Address, chip select and data must be held for one clock cycle past the fall.
- R3: A host read with `host_cs` high makes `host_doe` high and drives the addressed register on `host_dout` by the third falling clock edge after `host_rd` rises, and keeps that value for as long as the strobe lasts.
- R4: Address 0 is the 16-bit data register and uses all of `host_din` and `host_dout`. Addresses 1 to 15 are 8-bit registers: they keep only `host_din[7:0]` or `fw_wdata[7:0]`, and bits 15:8 read as zero on both ports.
- R5: `host_doe` is low when idle, during host writes, within six clock cycles after `host_rd` falls, and throughout any read with `host_cs` low. A write with `host_cs` low changes no register and raises no flag.
- R6: A firmware write (`fw_we` high at a rising clock edge) stores `fw_wdata` into the register at `fw_addr`. `fw_rdata` presents the register at `fw_addr` one cycle after the address is applied.
- R7: If a host write and a firmware write commit to the same register at the same clock edge, the register takes the host value.
- R8: Each committed host write pulses bit `host_addr` of `host_wr_flag` high for exactly one cycle. No other bit goes high.
- R9: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz or faster |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select, active high, asynchronous |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_wr | input | 1 | Host write strobe, active high, asynchronous |
| host_addr | input | 4 | Host register address |
| host_din | input | 16 | Host data bus, inbound half |
| host_dout | output | 16 | Host data bus, outbound half |
| host_doe | output | 1 | Output enable for the host data bus drivers |
| fw_we | input | 1 | Firmware write enable |
| fw_addr | input | 4 | Firmware register address |
| fw_wdata | input | 16 | Firmware write data |
| fw_rdata | output | 16 | Firmware read data, registered |
| host_wr_flag | output | 16 | One-cycle pulse per register on host write commit |

## Verification
The hardest case to reach from the ports is a host write and a firmware write landing on the same register at the same clock edge. The host commit happens a few synchronizer cycles after an asynchronous strobe edge, so it does not fall at a cycle the bench can pick in advance. The bench therefore holds `fw_we` on the target register for the whole host write and watches `host_wr_flag` at every falling edge. It drops `fw_we` in the half cycle after the flag appears. This guarantees that both writes met at the commit edge and that no later firmware write covers up the outcome. The bench does this for both the 16-bit register and an 8-bit register. It also sweeps all sixteen addresses on both ports, with strobe widths ranging from the three-cycle minimum to about 100 ns.

// File: rtl/taskfile_pkg.sv
package taskfile_pkg;
  localparam int TF_ADDR_W   = 4;
  localparam int TF_WIDE_W   = 16;
  localparam int TF_NARROW_W = 8;
  localparam int TF_WIDE_IDX = 0;
  localparam int TF_SYNC_N   = 2;
endpackage

// File: rtl/tf_strobe_sync.sv
module tf_strobe_sync #(
  parameter int  STAGES    = 2,
  parameter bit  EDGE_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic early,
  output logic lvl,
  output logic edge_pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign early = chain[0];
  assign lvl   = chain[STAGES-1];

  generate
    if (EDGE_RISE) begin : g_rise
      assign edge_pulse = chain[STAGES-1] & ~chain[STAGES];
    end else begin : g_fall
      assign edge_pulse = chain[STAGES] & ~chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tf_addr_decode.sv
module tf_addr_decode #(
  parameter int AW = 4
) (
  input  logic              en,
  input  logic [AW-1:0]     addr,
  output logic [(1<<AW)-1:0] sel
);
  localparam int LO  = AW / 2;
  localparam int HI  = AW - LO;
  localparam int NLO = 1 << LO;
  localparam int NHI = 1 << HI;

  logic [NHI-1:0] grp_en;

  generate
    for (genvar g = 0; g < NHI; g++) begin : g_grp
      assign grp_en[g] = en && (addr[AW-1:LO] == HI'(g));
      for (genvar k = 0; k < NLO; k++) begin : g_ent
        assign sel[g*NLO+k] = grp_en[g] && (addr[LO-1:0] == LO'(k));
      end
    end
  endgenerate
endmodule

// File: rtl/tf_reg_slice.sv
module tf_reg_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_we,
  input  logic [W-1:0] host_d,
  input  logic         fw_we,
  input  logic [W-1:0] fw_d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (host_we) q <= host_d;
    else if (fw_we)   q <= fw_d;
  end

  assert_host_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (host_we && fw_we) |=> (q == $past(host_d)));

  assert_fw_store_R6: assert property (@(posedge clk) disable iff (rst)
    (fw_we && !host_we) |=> (q == $past(fw_d)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!host_we && !fw_we) |=> $stable(q));
endmodule

// File: rtl/taskfile_bank.sv
module taskfile_bank
  import taskfile_pkg::*;
#(
  parameter int AW          = TF_ADDR_W,
  parameter int DW          = TF_WIDE_W,
  parameter int NW          = TF_NARROW_W,
  parameter int WIDE_IDX    = TF_WIDE_IDX,
  parameter int SYNC_STAGES = TF_SYNC_N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_cs,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [AW-1:0]        host_addr,
  input  logic [DW-1:0]        host_din,
  output logic [DW-1:0]        host_dout,
  output logic                 host_doe,
  input  logic                 fw_we,
  input  logic [AW-1:0]        fw_addr,
  input  logic [DW-1:0]        fw_wdata,
  output logic [DW-1:0]        fw_rdata,
  output logic [(1<<AW)-1:0]   host_wr_flag
);
  localparam int NREG = 1 << AW;

  // synchronized strobes
  logic rd_early, rd_lvl, rd_rise;
  logic wr_early, wr_lvl, wr_fall;

  tf_strobe_sync #(.STAGES(SYNC_STAGES), .EDGE_RISE(1'b1)) u_rd_sync (
    .clk(clk), .rst(rst), .async_in(host_rd),
    .early(rd_early), .lvl(rd_lvl), .edge_pulse(rd_rise));

  tf_strobe_sync #(.STAGES(SYNC_STAGES), .EDGE_RISE(1'b0)) u_wr_sync (
    .clk(clk), .rst(rst), .async_in(host_wr),
    .early(wr_early), .lvl(wr_lvl), .edge_pulse(wr_fall));

  // host bus sampled while a strobe is seen high
  logic            cap_cs;
  logic [AW-1:0]   cap_addr;
  logic [DW-1:0]   cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_cs   <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else if (rd_early || wr_early) begin
      cap_cs   <= host_cs;
      cap_addr <= host_addr;
      cap_data <= host_din;
    end
  end

  logic host_commit, rd_lead;
  assign host_commit = wr_fall && cap_cs;
  assign rd_lead     = rd_rise && cap_cs;

  // register selects
  logic [NREG-1:0] host_sel, fw_sel;

  tf_addr_decode #(.AW(AW)) u_host_dec (
    .en(host_commit), .addr(cap_addr), .sel(host_sel));

  tf_addr_decode #(.AW(AW)) u_fw_dec (
    .en(fw_we), .addr(fw_addr), .sel(fw_sel));

  // storage
  logic [DW-1:0] rd_arr [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == WIDE_IDX) begin : g_wide
        logic [DW-1:0] q;
        tf_reg_slice #(.W(DW)) u_slice (
          .clk(clk), .rst(rst),
          .host_we(host_sel[i]), .host_d(cap_data),
          .fw_we(fw_sel[i]),     .fw_d(fw_wdata),
          .q(q));
        assign rd_arr[i] = q;
      end else begin : g_narrow
        logic [NW-1:0] q;
        tf_reg_slice #(.W(NW)) u_slice (
          .clk(clk), .rst(rst),
          .host_we(host_sel[i]), .host_d(cap_data[NW-1:0]),
          .fw_we(fw_sel[i]),     .fw_d(fw_wdata[NW-1:0]),
          .q(q));
        assign rd_arr[i] = {{(DW-NW){1'b0}}, q};
      end
    end
  endgenerate

  // host read path and bus turnaround
  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout <= '0;
      host_doe  <= 1'b0;
    end else if (rd_lead) begin
      host_dout <= rd_arr[cap_addr];
      host_doe  <= 1'b1;
    end else begin
      host_doe  <= host_doe && rd_lvl && !wr_lvl;
    end
  end

  // firmware read path and host write flags
  always_ff @(posedge clk) begin
    if (rst) begin
      fw_rdata     <= '0;
      host_wr_flag <= '0;
    end else begin
      fw_rdata     <= rd_arr[fw_addr];
      host_wr_flag <= host_sel;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!host_doe && fw_rdata == '0 && host_wr_flag == '0));

  assert_flag_single_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(host_wr_flag));

  assert_oe_release_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd_lvl) |=> !host_doe);

  assert_host_narrow_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_lead && cap_addr != AW'(WIDE_IDX)) |=> (host_dout[DW-1:NW] == '0));

  assert_fw_narrow_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (fw_addr != AW'(WIDE_IDX)) |=> (fw_rdata[DW-1:NW] == '0));
endmodule

// File: tb/taskfile_bank_test.sv
module taskfile_bank_test;
  localparam int NREG = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, host_cs, host_rd, host_wr, host_doe, fw_we;
  logic [3:0]  host_addr, fw_addr;
  logic [15:0] host_din, host_dout, fw_wdata, fw_rdata, host_wr_flag;

  taskfile_bank uut (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout),
    .host_doe(host_doe), .fw_we(fw_we), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
    .fw_rdata(fw_rdata), .host_wr_flag(host_wr_flag));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] model [NREG];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [15:0] fit(int a, logic [15:0] v);
    return (a == 0) ? v : {8'h00, v[7:0]};
  endfunction

  task automatic host_write(int a, logic [15:0] d, logic cs, int width,
                            output logic [15:0] flags, output int fcyc, output int oeh);
    flags = '0; fcyc = 0; oeh = 0;
    @(negedge clk);
    host_addr = 4'(a); host_din = d; host_cs = cs; host_wr = 1'b1;
    for (int k = 0; k < width + 10; k++) begin
      @(negedge clk);
      if (k == width - 1) host_wr = 1'b0;
      if (k == width + 1) begin host_cs = 1'b0; host_din = ~d; end
      if (host_wr_flag != 0) begin flags |= host_wr_flag; fcyc++; end
      if (host_doe) oeh++;
    end
  endtask

  task automatic host_read(int a, logic cs, int width,
                           output logic [15:0] dout, output logic oe_mid,
                           output logic oe_after);
    @(negedge clk);
    host_addr = 4'(a); host_cs = cs; host_rd = 1'b1;
    repeat (width) @(negedge clk);
    dout = host_dout; oe_mid = host_doe;
    host_rd = 1'b0;
    repeat (2) @(negedge clk);
    host_cs = 1'b0;
    repeat (4) @(negedge clk);
    oe_after = host_doe;
  endtask

  task automatic fw_write(int a, logic [15:0] d);
    @(negedge clk);
    fw_addr = 4'(a); fw_wdata = d; fw_we = 1'b1;
    @(negedge clk);
    fw_we = 1'b0;
  endtask

  task automatic fw_read(int a, output logic [15:0] v);
    @(negedge clk);
    fw_addr = 4'(a); fw_we = 1'b0;
    @(negedge clk);
    v = fw_rdata;
  endtask

  task automatic collide(int a, logic [15:0] hd, logic [15:0] fd);
    bit seen = 1'b0;
    logic [15:0] v;
    @(negedge clk);
    fw_addr = 4'(a); fw_wdata = fd; fw_we = 1'b1;
    host_addr = 4'(a); host_din = hd; host_cs = 1'b1; host_wr = 1'b1;
    repeat (5) @(negedge clk);
    host_wr = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 1) host_cs = 1'b0;
      if (host_wr_flag[a]) begin seen = 1'b1; fw_we = 1'b0; end
    end
    fw_we = 1'b0;
    check($sformatf("R7 collision flag seen addr %0d", a), 32'(seen), 32'd1);
    model[a] = fit(a, hd);
    fw_read(a, v);
    check($sformatf("R7 host wins addr %0d", a), 32'(v), 32'(model[a]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [15:0] v, flags, d;
    logic oe_mid, oe_after;
    int fcyc, oeh;

    rst = 1'b1; host_cs = 0; host_rd = 0; host_wr = 0; host_addr = 0;
    host_din = 0; fw_we = 0; fw_addr = 0; fw_wdata = 0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    check("R1 oe in reset", 32'(host_doe), 32'd0);
    check("R1 fw_rdata in reset", 32'(fw_rdata), 32'd0);
    check("R1 flags in reset", 32'(host_wr_flag), 32'd0);
    rst = 1'b0;

    for (int a = 0; a < NREG; a++) begin
      fw_read(a, v);
      check($sformatf("R1 reg %0d zero after reset", a), 32'(v), 32'd0);
    end
    host_read(5, 1'b1, 4, v, oe_mid, oe_after);
    check("R1 host read after reset", 32'(v), 32'd0);

    // host write sweep, strobe widths from 3 to 24 cycles
    for (int a = 0; a < NREG; a++) begin
      d = 16'h3C5A ^ 16'(a * 16'h1357);
      host_write(a, d, 1'b1, 3 + (a % 4) * 7, flags, fcyc, oeh);
      model[a] = fit(a, d);
      check($sformatf("R8 flag bit addr %0d", a), 32'(flags), 32'(16'd1 << a));
      check($sformatf("R8 flag width addr %0d", a), 32'(fcyc), 32'd1);
      check($sformatf("R5 oe low during write %0d", a), 32'(oeh), 32'd0);
    end
    for (int a = 0; a < NREG; a++) begin
      fw_read(a, v);
      check($sformatf("R2 R4 R9 fw view of host write %0d", a), 32'(v), 32'(model[a]));
    end
    for (int a = 0; a < NREG; a++) begin
      host_read(a, 1'b1, 3 + (a % 3) * 10, v, oe_mid, oe_after);
      check($sformatf("R3 R4 host read data %0d", a), 32'(v), 32'(model[a]));
      check($sformatf("R3 oe during read %0d", a), 32'(oe_mid), 32'd1);
      check($sformatf("R5 oe released after read %0d", a), 32'(oe_after), 32'd0);
    end

    // firmware write sweep, read back on both ports
    for (int a = 0; a < NREG; a++) begin
      d = ~(16'(a * 16'h0F1E)) + 16'(a);
      fw_write(a, d);
      model[a] = fit(a, d);
    end
    for (int a = 0; a < NREG; a++) begin
      fw_read(a, v);
      check($sformatf("R6 fw readback %0d", a), 32'(v), 32'(model[a]));
      host_read(a, 1'b1, 5, v, oe_mid, oe_after);
      check($sformatf("R6 R4 host sees fw write %0d", a), 32'(v), 32'(model[a]));
    end

    // deselected accesses
    host_write(3, 16'hBEEF, 1'b0, 6, flags, fcyc, oeh);
    check("R5 no flag on deselected write", 32'(flags), 32'd0);
    fw_read(3, v);
    check("R5 deselected write ignored", 32'(v), 32'(model[3]));
    host_write(0, 16'h1234, 1'b0, 4, flags, fcyc, oeh);
    fw_read(0, v);
    check("R5 deselected write ignored wide", 32'(v), 32'(model[0]));
    host_read(7, 1'b0, 8, v, oe_mid, oe_after);
    check("R5 no drive on deselected read", 32'(oe_mid), 32'd0);
    repeat (3) @(negedge clk);
    check("R5 oe idle", 32'(host_doe), 32'd0);

    // simultaneous host and firmware writes
    collide(0, 16'hA1B2, 16'h5566);
    collide(9, 16'h00C7, 16'h0033);
    for (int a = 0; a < NREG; a++) begin
      fw_read(a, v);
      check($sformatf("R9 final state %0d", a), 32'(v), 32'(model[a]));
    end

    summary();
  end
endmodule